// File: doc/BRIEF.md
# Two-Step Subranging Converter Decoder

This block is the digital sequencer and decoder behind a two-step subranging flash converter producing a 10-bit code. A small estimator bank gives a rough idea of where the input sits. From that estimate the block picks a window of sixteen coarse-ladder taps and routes them to one shared bank of sixteen comparators. The shared bank is then read twice. The first read sets the six upper bits. The second read sets the four lower bits: the analog front end compares the residue against a fine ladder.

The window is wider than the estimate on both sides by one sixteenth of full scale. A wrong estimate therefore still produces the correct upper bits, as long as the error stays within that margin. All thermometer codes are turned into numbers by counting their asserted bits. A single out-of-place comparator therefore does not corrupt the count.

A conversion begins when `start` is sampled high while the block is idle. It then passes through three single-clock phases: estimate, coarse flash and fine flash. A one-cycle strobe follows, and the latched word is held until the next conversion.

Top module: `subrange_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `fine_phase` and `result_valid` are 0, and `result` and `win_base` are 0.
- R2: If `start` is sampled high at an edge while idle, `busy` is 1 for the next three cycles and `result_valid` is 1 for exactly the following cycle.
- R3: Estimator bit k is 1 when the input is at least (k+1)*128 LSB. From the count c of ones, `win_base` is set as follows: 0 for c=0, 48 for c=6, and 8c-4 otherwise. The value is presented from the second cycle of a conversion and held until the next estimate.
- R4: In the coarse phase, bank bit j is 1 when the input is at least (`win_base`+j+1)*16 LSB. The upper six result bits equal `win_base` plus the number of ones, saturated at 63.
- R5: `fine_phase` is 1 only during the third cycle of a conversion. In that cycle bank bit j is 1 when the residue is at least j+1 LSB. The lower four result bits equal the number of ones, saturated at 15.
- R6: `result` = {coarse code, fine code}. It changes only when `result_valid` rises, and it holds between conversions.
- R7: For estimates with c from 0 to 5, an estimator error of up to 64 LSB in either direction still yields the exact input code.
- R8: A thermometer with a bubble (one 0 below a 1) decodes to the same count as the clean code with the same number of ones.
- R9: A `start` held high during a conversion is ignored. No second conversion follows, and `busy` is 0 in the cycle after the fine phase.
- R10: With ideal comparators, every input code from 0 to 1023 converts to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| est_therm | input | 6 | Estimator comparator thermometer |
| bank_therm | input | 16 | Shared comparator bank thermometer |
| win_base | output | 6 | Lowest coarse tap of the selected window |
| fine_phase | output | 1 | Shared bank is comparing the residue |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Latched conversion word |
| result_valid | output | 1 | One-cycle strobe on a new result |

## Verification
A wrong window base shows up on `win_base` one cycle after `start` is taken. It also appears two cycles later as an upper code offset by the base error, or stuck at a window edge. A phase sequencer that has lost step shows up as `fine_phase` or `result_valid` landing in the wrong cycle, or as `busy` failing to drop right after the fine phase. A counting or saturation fault appears in `result` on the strobe itself.

// File: rtl/subrange_pkg.sv
`timescale 1ns/1ps
package subrange_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EST  = 2'd1,
    PH_CRS  = 2'd2,
    PH_FIN  = 2'd3
  } phase_e;

endpackage

// File: rtl/subrange_ones.sv
`timescale 1ns/1ps
// Counts asserted bits of a thermometer word; bubbles do not disturb the total.
module subrange_ones #(
  parameter int N = 16,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] therm,
  output logic [W-1:0] ones
);

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) begin
      ones = ones + W'(therm[i]);
    end
  end

endmodule

// File: rtl/subrange_window.sv
`timescale 1ns/1ps
// Maps the estimator count onto the lowest tap of an overlapping window.
module subrange_window #(
  parameter int EST_N    = 6,
  parameter int BANK_N   = 16,
  parameter int COARSE_W = 6,
  parameter int CNT_W    = $clog2(EST_N + 1)
) (
  input  logic [CNT_W-1:0]    est_cnt,
  output logic [COARSE_W-1:0] base
);

  localparam int TAPS     = 1 << COARSE_W;
  localparam int REGION   = BANK_N / 2;
  localparam int MARGIN   = BANK_N / 4;
  localparam int TOP_BASE = TAPS - BANK_N;

  int raw_base;

  always_comb begin
    raw_base = int'(est_cnt) * REGION - MARGIN;
    if (est_cnt == '0) begin
      base = '0;
    end else if (int'(est_cnt) >= EST_N || raw_base > TOP_BASE) begin
      base = COARSE_W'(TOP_BASE);
    end else if (raw_base < 0) begin
      base = '0;
    end else begin
      base = COARSE_W'(raw_base);
    end
  end

endmodule

// File: rtl/subrange_seq.sv
`timescale 1ns/1ps
// Three single-cycle phases per conversion: estimate, coarse, fine.
module subrange_seq
  import subrange_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   busy
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_EST;
      PH_EST:  phase_d = PH_CRS;
      PH_CRS:  phase_d = PH_FIN;
      PH_FIN:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;
  assign busy  = (phase_q != PH_IDLE);

endmodule

// File: rtl/subrange_decoder.sv
`timescale 1ns/1ps
module subrange_decoder
  import subrange_pkg::*;
#(
  parameter int EST_N    = 6,
  parameter int BANK_N   = 16,
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [EST_N-1:0]           est_therm,
  input  logic [BANK_N-1:0]          bank_therm,
  output logic [COARSE_W-1:0]        win_base,
  output logic                       fine_phase,
  output logic                       busy,
  output logic [COARSE_W+FINE_W-1:0] result,
  output logic                       result_valid
);

  localparam int EST_CW     = $clog2(EST_N + 1);
  localparam int BANK_CW    = $clog2(BANK_N + 1);
  localparam int RES_W      = COARSE_W + FINE_W;
  localparam int COARSE_MAX = (1 << COARSE_W) - 1;
  localparam int FINE_MAX   = (1 << FINE_W) - 1;

  phase_e               phase;
  logic [EST_CW-1:0]    est_ones;
  logic [BANK_CW-1:0]   bank_ones;
  logic [COARSE_W-1:0]  base_d;
  logic                 est_en;
  logic                 crs_en;
  logic                 fin_en;
  int                   coarse_sum;
  logic [COARSE_W-1:0]  coarse_d;
  logic [COARSE_W-1:0]  coarse_q;
  logic [FINE_W-1:0]    fine_d;
  logic [COARSE_W-1:0]  base_q;
  logic [RES_W-1:0]     result_q;
  logic                 valid_q;

  subrange_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .phase (phase),
    .busy  (busy)
  );

  subrange_ones #(.N(EST_N), .W(EST_CW)) u_est_ones (
    .therm (est_therm),
    .ones  (est_ones)
  );

  subrange_ones #(.N(BANK_N), .W(BANK_CW)) u_bank_ones (
    .therm (bank_therm),
    .ones  (bank_ones)
  );

  subrange_window #(
    .EST_N    (EST_N),
    .BANK_N   (BANK_N),
    .COARSE_W (COARSE_W),
    .CNT_W    (EST_CW)
  ) u_window (
    .est_cnt (est_ones),
    .base    (base_d)
  );

  // Phase-derived clock enables
  always_comb begin
    est_en = (phase == PH_EST);
    crs_en = (phase == PH_CRS);
    fin_en = (phase == PH_FIN);
  end

  // Next-value logic for coarse and fine codes
  always_comb begin
    coarse_sum = int'(base_q) + int'(bank_ones);
    if (coarse_sum > COARSE_MAX) begin
      coarse_d = COARSE_W'(COARSE_MAX);
    end else begin
      coarse_d = COARSE_W'(coarse_sum);
    end
    if (int'(bank_ones) > FINE_MAX) begin
      fine_d = FINE_W'(FINE_MAX);
    end else begin
      fine_d = FINE_W'(bank_ones);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (est_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
    end else if (crs_en) begin
      coarse_q <= coarse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (fin_en) begin
      result_q <= {coarse_q, fine_d};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= fin_en;
    end
  end

  assign win_base     = base_q;
  assign fine_phase   = fin_en;
  assign result       = result_q;
  assign result_valid = valid_q;

endmodule

// File: rtl/subrange_checker.sv
`timescale 1ns/1ps
module subrange_checker #(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       busy,
  input logic                       fine_phase,
  input logic [COARSE_W-1:0]        win_base,
  input logic [COARSE_W+FINE_W-1:0] result,
  input logic                       result_valid
);

  localparam int TOP_BASE = (1 << COARSE_W) - 16;

  a_r2_valid_after_fine: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(fine_phase));

  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  a_r3_window_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(win_base) <= TOP_BASE);

  a_r4_coarse_floor: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (result[COARSE_W+FINE_W-1:FINE_W] >= win_base));

  a_r5_fine_single: assert property (@(posedge clk) disable iff (!rst_n)
    fine_phase |=> !fine_phase);

  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));

  a_r9_idle_after_fine: assert property (@(posedge clk) disable iff (!rst_n)
    fine_phase |=> !busy);

  a_r9_start_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

bind subrange_decoder subrange_checker #(
  .COARSE_W (COARSE_W),
  .FINE_W   (FINE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .fine_phase   (fine_phase),
  .win_base     (win_base),
  .result       (result),
  .result_valid (result_valid)
);

// File: tb/subrange_decoder_tb.sv
`timescale 1ns/1ps
module subrange_decoder_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [5:0]  est_therm;
  logic [15:0] bank_therm;
  logic [5:0]  win_base;
  logic        fine_phase;
  logic        busy;
  logic [9:0]  result;
  logic        result_valid;

  int  n_chk;
  int  n_fail;
  bit  done;

  // analog model controls
  int  vin;
  int  est_err;
  int  crs_tap;
  bit  bubble_en;
  bit  force_crs;
  bit  force_fin;

  int          a_ve;
  int          a_res;
  int          a_n;
  logic [15:0] a_bank;

  subrange_decoder u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .est_therm    (est_therm),
    .bank_therm   (bank_therm),
    .win_base     (win_base),
    .fine_phase   (fine_phase),
    .busy         (busy),
    .result       (result),
    .result_valid (result_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int est_count(int v);
    int c;
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    c = v / 128;
    if (c > 6) c = 6;
    return c;
  endfunction

  function automatic int exp_base(int c);
    if (c == 0) return 0;
    if (c == 6) return 48;
    return 8 * c - 4;
  endfunction

  function automatic int model_coarse(int v, int b);
    int n;
    n = v / 16 - b;
    if (n < 0) n = 0;
    if (n > 16) n = 16;
    if (b + n > 63) return 63;
    return b + n;
  endfunction

  // Behavioural comparator banks
  always_comb begin
    a_ve = vin + est_err;
    if (a_ve < 0) a_ve = 0;
    if (a_ve > 1023) a_ve = 1023;
    for (int k = 0; k < 6; k++) est_therm[k] = (a_ve >= (k + 1) * 128);
    a_res = vin - crs_tap * 16;
    a_n = 0;
    for (int j = 0; j < 16; j++) begin
      if (!fine_phase) a_bank[j] = (vin >= (int'(win_base) + j + 1) * 16);
      else             a_bank[j] = (a_res >= j + 1);
      if (a_bank[j]) a_n = a_n + 1;
    end
    if (bubble_en && a_n >= 2 && a_n <= 15) begin
      a_bank[a_n - 2] = 1'b0;
      a_bank[a_n]     = 1'b1;
    end
    if (force_crs && !fine_phase) a_bank = '1;
    if (force_fin && fine_phase)  a_bank = '1;
    bank_therm = a_bank;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_conv(input int v, input int err, input bit bub, input bit fc,
                         input bit ff, input bit hold, input int exp_res, input string tag);
    int c;
    int b;
    vin = v; est_err = err; bubble_en = bub; force_crs = fc; force_fin = ff;
    c = est_count(v + err);
    b = exp_base(c);
    if (fc) crs_tap = (b + 16 > 63) ? 63 : b + 16;
    else    crs_tap = model_coarse(v, b);
    @(negedge clk) start = 1'b1;
    @(negedge clk) if (!hold) start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    @(negedge clk);
    chk(int'(win_base) == b, "R3 window base", int'(win_base), b);
    chk(fine_phase == 1'b0, "R5 fine_phase in coarse cycle", int'(fine_phase), 0);
    @(negedge clk) start = 1'b0;
    chk(fine_phase == 1'b1, "R5 fine_phase in fine cycle", int'(fine_phase), 1);
    @(negedge clk);
    chk(result_valid == 1'b1, "R2 valid strobe", int'(result_valid), 1);
    chk(int'(result) == exp_res, tag, int'(result), exp_res);
    chk(busy == 1'b0, "R9 idle after fine", int'(busy), 0);
    @(negedge clk);
    chk(result_valid == 1'b0, "R2 strobe one cycle", int'(result_valid), 0);
    chk(busy == 1'b0, "R9 no extra conversion", int'(busy), 0);
    chk(int'(result) == exp_res, "R6 result held", int'(result), exp_res);
    bubble_en = 1'b0; force_crs = 1'b0; force_fin = 1'b0; est_err = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(result_valid == 1'b0, "R1 valid in reset", int'(result_valid), 0);
    chk(result == '0, "R1 result in reset", int'(result), 0);
    chk(win_base == '0, "R1 win_base in reset", int'(win_base), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(fine_phase == 1'b0, "R1 fine_phase after reset", int'(fine_phase), 0);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 1024; v++) do_conv(v, 0, 1'b0, 1'b0, 1'b0, 1'b0, v, "R10 ideal sweep");
  endtask

  task automatic t_est_error();
    do_conv(100, 64, 1'b0, 1'b0, 1'b0, 1'b0, 100, "R7 estimate high c=1");
    do_conv(300, 64, 1'b0, 1'b0, 1'b0, 1'b0, 300, "R7 estimate high");
    do_conv(300, -64, 1'b0, 1'b0, 1'b0, 1'b0, 300, "R7 estimate low");
    do_conv(500, 63, 1'b0, 1'b0, 1'b0, 1'b0, 500, "R7 estimate high");
    do_conv(640, -64, 1'b0, 1'b0, 1'b0, 1'b0, 640, "R7 estimate low");
    do_conv(700, 64, 1'b0, 1'b0, 1'b0, 1'b0, 700, "R7 estimate high c=5");
    do_conv(60, -50, 1'b0, 1'b0, 1'b0, 1'b0, 60, "R7 estimate low c=0");
  endtask

  task automatic t_bubble();
    do_conv(77, 0, 1'b1, 1'b0, 1'b0, 1'b0, 77, "R8 bubble low");
    do_conv(413, 0, 1'b1, 1'b0, 1'b0, 1'b0, 413, "R8 bubble mid");
    do_conv(851, 0, 1'b1, 1'b0, 1'b0, 1'b0, 851, "R8 bubble high");
    do_conv(1013, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1013, "R8 bubble top");
  endtask

  task automatic t_saturate();
    do_conv(800, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1008, "R4 coarse saturates at 63");
    do_conv(512, 0, 1'b0, 1'b0, 1'b1, 1'b0, 527, "R5 fine saturates at 15");
    do_conv(200, 0, 1'b0, 1'b1, 1'b0, 1'b0, 320, "R4 coarse base plus sixteen");
  endtask

  task automatic t_busy_start();
    do_conv(333, 0, 1'b0, 1'b0, 1'b0, 1'b1, 333, "R9 start held during conversion");
    do_conv(999, 0, 1'b0, 1'b0, 1'b0, 1'b1, 999, "R9 start held during conversion");
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    vin = 0; est_err = 0; crs_tap = 0;
    bubble_en = 1'b0; force_crs = 1'b0; force_fin = 1'b0;
    rst_n = 1'b0; start = 1'b0;
    t_reset();
    t_sweep();
    t_est_error();
    t_bubble();
    t_saturate();
    t_busy_start();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule